// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation after a TLB miss. A 14-bit virtual address splits into an 8-bit virtual page number and a 6-bit byte offset, which gives 64-byte pages. The block receives only the page number, the kind of access requested and the physical base address of the page directory. It then walks a two-level table held in memory. The upper half of the page number selects one of 16 directory words. That word points at a page of 16 table words, and the lower half of the page number selects one of them.

The walker reads one 32-bit word at a time on a request/grant port, with a response that returns later on a separate valid strobe. It finishes every walk with exactly one of two results. The first is a one-cycle insert pulse that carries the page number, frame number and permission bits for the TLB; this pulse also tells the requester to retry the instruction. The second is a one-cycle fault pulse with a 2-bit code. Only one walk is in flight at a time, and a new request waits until the walker is idle again.

Top module: `pt_walker`

## Requirements
- R1: After reset `walk_ready` is 1, and `mem_req`, `ins_valid` and `flt_valid` are all 0.
- R2: A request is taken in a cycle where both `walk_valid` and `walk_ready` are high. `walk_ready` then stays low until the result pulse has ended. While it is low, `walk_valid` and `walk_vpn` have no effect on the walk.
- R3: The first read is the directory entry, at byte address `dir_base + 4*vpn[7:4]`, truncated to 14 bits.
- R4: `mem_req` stays high with an unchanged `mem_addr` until `mem_gnt` is seen. The response may arrive any number of cycles after the grant. `mem_rvalid` has no effect while no granted read is pending.
- R5: Entry bit 31 is the valid flag. A directory entry with bit 31 clear ends the walk with fault code 01 (segmentation), and no second read is issued.
- R6: The second read is the table entry, at byte address `{pde[7:0], 6'b0} | 4*vpn[3:0]`. Frame numbers sit in entry bits 7:0.
- R7: A table entry with bit 31 clear gives fault code 01 (segmentation). This applies whatever its other bits hold.
- R8: Entry bits 29, 28 and 27 grant read, write and execute. `walk_acc[2:0]` uses the same order: [2] read, [1] write, [0] execute. A valid table entry that lacks any requested permission gives fault code 10 (protection), whatever its present bit holds.
- R9: Entry bit 30 is the present flag. A valid, permitted table entry with bit 30 clear gives fault code 11 (page not present).
- R10: A valid, permitted, present table entry gives an `ins_valid` pulse. The pulse carries the request's page number, a frame of `pte[7:0]` and permissions of `pte[29:27]`.
- R11: Each walk ends with exactly one single-cycle pulse, on `ins_valid` or on `flt_valid`, never both. `walk_ready` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| walk_valid | input | 1 | Walk request |
| walk_ready | output | 1 | Walker idle, request can be taken |
| walk_vpn | input | 8 | Virtual page number to translate |
| walk_acc | input | 3 | Requested access: read, write, execute |
| dir_base | input | 14 | Physical byte address of the page directory |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 14 | Byte address of the word to read |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| ins_valid | output | 1 | Translation ready for insertion; retry the instruction |
| ins_vpn | output | 8 | Page number of the translation |
| ins_pfn | output | 8 | Frame number of the translation |
| ins_prot | output | 3 | Read, write, execute permissions |
| flt_valid | output | 1 | Walk ended in a fault |
| flt_code | output | 2 | 01 segmentation, 10 protection, 11 not present |

## Verification
A state machine that lands in the wrong state shows up at the memory port first, as a read that is missing, repeated or aimed at the wrong address. This appears within a cycle of the grant or of the response that should have moved the walk on. A mix-up between the directory frame and the table frame shows as a wrong second address or a wrong inserted frame. If the checks in the wrong order, the fault code is wrong, and the cases where several faults apply at once are built to expose this. If busy state leaks, `walk_ready` or the result pulses misbehave in the cycle right after the result.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VPN_W = 8,
  parameter int OFF_W = 6,
  parameter int DIR_W = 4,
  parameter int PA_W  = 14,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             walk_valid,
  output logic             walk_ready,
  input  logic [VPN_W-1:0] walk_vpn,
  input  logic [2:0]       walk_acc,
  input  logic [PA_W-1:0]  dir_base,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_gnt,
  input  logic             mem_rvalid,
  input  logic [DW-1:0]    mem_rdata,
  output logic             ins_valid,
  output logic [VPN_W-1:0] ins_vpn,
  output logic [PA_W-OFF_W-1:0] ins_pfn,
  output logic [2:0]       ins_prot,
  output logic             flt_valid,
  output logic [1:0]       flt_code
);
  localparam int PT_W  = VPN_W - DIR_W;
  localparam int PFN_W = PA_W - OFF_W;
  localparam int V_BIT = DW - 1;
  localparam int P_BIT = DW - 2;
  localparam int R_TOP = DW - 3;
  localparam logic [1:0] F_SEG  = 2'b01;
  localparam logic [1:0] F_PROT = 2'b10;
  localparam logic [1:0] F_PAGE = 2'b11;

  typedef enum logic [2:0] {IDLE, READ_PDE, WAIT_PDE, READ_PTE, WAIT_PTE, DONE, FAULT} st_t;

  st_t              st;
  logic [VPN_W-1:0] vpn_q;
  logic [2:0]       acc_q;
  logic [PFN_W-1:0] pfn_q;
  logic [2:0]       prot_q;
  logic [1:0]       code_q;

  logic [2:0]      rd_prot;
  logic            rd_deny;
  logic [PA_W-1:0] pde_addr, pte_addr;

  assign rd_prot  = mem_rdata[R_TOP -: 3];
  assign rd_deny  = |(acc_q & ~rd_prot);
  assign pde_addr = dir_base + PA_W'({vpn_q[VPN_W-1 -: DIR_W], 2'b00});
  assign pte_addr = {pfn_q, {OFF_W{1'b0}}} | PA_W'({vpn_q[PT_W-1:0], 2'b00});

  assign walk_ready = (st == IDLE);
  assign mem_req    = (st == READ_PDE) || (st == READ_PTE);
  assign mem_addr   = (st == READ_PTE) ? pte_addr : pde_addr;
  assign ins_valid  = (st == DONE);
  assign flt_valid  = (st == FAULT);
  assign ins_vpn    = vpn_q;
  assign ins_pfn    = pfn_q;
  assign ins_prot   = prot_q;
  assign flt_code   = code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      vpn_q  <= '0;
      acc_q  <= '0;
      pfn_q  <= '0;
      prot_q <= '0;
      code_q <= '0;
    end else begin
      case (st)
        IDLE: if (walk_valid) begin
          vpn_q <= walk_vpn;
          acc_q <= walk_acc;
          st    <= READ_PDE;
        end
        READ_PDE: if (mem_gnt) st <= WAIT_PDE;
        WAIT_PDE: if (mem_rvalid) begin
          if (!mem_rdata[V_BIT]) begin
            code_q <= F_SEG;
            st     <= FAULT;
          end else begin
            pfn_q <= mem_rdata[PFN_W-1:0];
            st    <= READ_PTE;
          end
        end
        READ_PTE: if (mem_gnt) st <= WAIT_PTE;
        WAIT_PTE: if (mem_rvalid) begin
          if (!mem_rdata[V_BIT]) begin
            code_q <= F_SEG;
            st     <= FAULT;
          end else if (rd_deny) begin
            code_q <= F_PROT;
            st     <= FAULT;
          end else if (!mem_rdata[P_BIT]) begin
            code_q <= F_PAGE;
            st     <= FAULT;
          end else begin
            pfn_q  <= mem_rdata[PFN_W-1:0];
            prot_q <= rd_prot;
            st     <= DONE;
          end
        end
        DONE:    st <= IDLE;
        FAULT:   st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VPN_W = 8,
  parameter int PA_W  = 14,
  parameter int PFN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             walk_valid,
  input logic             walk_ready,
  input logic [VPN_W-1:0] walk_vpn,
  input logic [2:0]       walk_acc,
  input logic             mem_req,
  input logic [PA_W-1:0]  mem_addr,
  input logic             mem_gnt,
  input logic             ins_valid,
  input logic [VPN_W-1:0] ins_vpn,
  input logic [2:0]       ins_prot,
  input logic             flt_valid,
  input logic [1:0]       flt_code
);
  logic [VPN_W-1:0] vpn_t;
  logic [2:0]       acc_t;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vpn_t <= '0;
      acc_t <= '0;
    end else if (walk_valid && walk_ready) begin
      vpn_t <= walk_vpn;
      acc_t <= walk_acc;
    end
  end

  p_hold_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    walk_ready |-> !mem_req && !ins_valid && !flt_valid);
  p_one_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ins_valid && flt_valid));
  p_pulse_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid || flt_valid |=> walk_ready && !ins_valid && !flt_valid);
  p_fault_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |-> flt_code != 2'b00);
  p_ins_vpn_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> ins_vpn == vpn_t);
  p_ins_perm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> (acc_t & ~ins_prot) == 3'b000);
endmodule

bind pt_walker pt_walker_chk #(.VPN_W(VPN_W), .PA_W(PA_W), .PFN_W(PA_W - OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .walk_valid(walk_valid), .walk_ready(walk_ready),
  .walk_vpn(walk_vpn), .walk_acc(walk_acc), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_gnt(mem_gnt), .ins_valid(ins_valid), .ins_vpn(ins_vpn), .ins_prot(ins_prot),
  .flt_valid(flt_valid), .flt_code(flt_code)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        walk_valid = 1'b0;
  logic        walk_ready;
  logic [7:0]  walk_vpn = '0;
  logic [2:0]  walk_acc = '0;
  logic [13:0] dir_base = '0;
  logic        mem_req;
  logic [13:0] mem_addr;
  logic        mem_gnt = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        ins_valid;
  logic [7:0]  ins_vpn;
  logic [7:0]  ins_pfn;
  logic [2:0]  ins_prot;
  logic        flt_valid;
  logic [1:0]  flt_code;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] mem [int unsigned];

  always #2 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .walk_valid(walk_valid), .walk_ready(walk_ready),
    .walk_vpn(walk_vpn), .walk_acc(walk_acc), .dir_base(dir_base),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ins_valid(ins_valid), .ins_vpn(ins_vpn), .ins_pfn(ins_pfn), .ins_prot(ins_prot),
    .flt_valid(flt_valid), .flt_code(flt_code)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [13:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] ent(input bit v, input bit p, input logic [2:0] prot,
                                      input logic [7:0] pfn, input logic [31:0] junk);
    return {v, p, prot, junk[26:8], pfn};
  endfunction

  task automatic walk(input logic [7:0] vpn, input logic [2:0] acc, input int gd,
                      input int rl, input bit noise);
    logic [13:0] a0, a1, got_a0, got_a1, cur;
    logic [31:0] pde, pte;
    int e_n, n, guard;
    bit e_ins;
    logic [1:0] e_code;
    logic [7:0] e_pfn;
    logic [2:0] e_prot;
    a0 = dir_base + {8'd0, vpn[7:4], 2'b00};
    pde = rd(a0);
    a1 = '0; e_ins = 0; e_code = 2'b00; e_pfn = '0; e_prot = '0;
    if (!pde[31]) begin
      e_n = 1; e_code = 2'b01;
    end else begin
      e_n = 2;
      a1 = {pde[7:0], 6'b0} | {8'd0, vpn[3:0], 2'b00};
      pte = rd(a1);
      if (!pte[31]) e_code = 2'b01;
      else if ((acc & ~pte[29:27]) != 3'b000) e_code = 2'b10;
      else if (!pte[30]) e_code = 2'b11;
      else begin e_ins = 1; e_pfn = pte[7:0]; e_prot = pte[29:27]; end
    end
    @(negedge clk);
    chk(walk_ready, "R2", "ready before request", walk_ready, 1);
    walk_valid = 1'b1; walk_vpn = vpn; walk_acc = acc;
    @(negedge clk);
    chk(!walk_ready, "R2", "busy after accept", walk_ready, 0);
    walk_valid = noise; walk_vpn = ~vpn; walk_acc = ~acc;
    n = 0; guard = 0; got_a0 = '0; got_a1 = '0;
    while (!(ins_valid || flt_valid) && guard < 400) begin
      guard++;
      if (mem_req) begin
        cur = mem_addr;
        if (n == 0) got_a0 = cur; else got_a1 = cur;
        for (int i = 0; i < gd; i++) begin
          mem_rvalid = noise; mem_rdata = $urandom;
          @(negedge clk);
          mem_rvalid = 1'b0;
          chk(mem_req && mem_addr == cur, "R4", "request held while not granted", mem_addr, cur);
        end
        mem_gnt = 1'b1;
        @(negedge clk);
        mem_gnt = 1'b0;
        for (int i = 0; i < rl; i++) @(negedge clk);
        mem_rvalid = 1'b1; mem_rdata = rd(cur);
        @(negedge clk);
        mem_rvalid = 1'b0; mem_rdata = $urandom;
        n++;
      end else begin
        @(negedge clk);
      end
    end
    walk_valid = 1'b0;
    chk(n == e_n, e_n == 1 ? "R5" : "R6", "read count", n, e_n);
    chk(got_a0 == a0, "R3", "directory address", got_a0, a0);
    if (e_n == 2) chk(got_a1 == a1, "R6", "table address", got_a1, a1);
    chk(!(ins_valid && flt_valid), "R11", "single result", {ins_valid, flt_valid}, e_ins ? 2 : 1);
    chk(ins_valid == e_ins, e_ins ? "R10" : "R11", "insert pulse", ins_valid, e_ins);
    chk(flt_valid == !e_ins, "R11", "fault pulse", flt_valid, !e_ins);
    if (e_ins) begin
      chk(ins_vpn == vpn, "R10", "insert vpn", ins_vpn, vpn);
      chk(ins_pfn == e_pfn, "R10", "insert pfn", ins_pfn, e_pfn);
      chk(ins_prot == e_prot, "R10", "insert prot", ins_prot, e_prot);
    end else begin
      chk(flt_code == e_code,
          e_code == 2'b10 ? "R8" : (e_code == 2'b11 ? "R9" : (e_n == 1 ? "R5" : "R7")),
          "fault code", flt_code, e_code);
    end
    @(negedge clk);
    chk(walk_ready && !ins_valid && !flt_valid, "R11", "idle after pulse",
        {walk_ready, ins_valid, flt_valid}, 3'b100);
  endtask

  task automatic setup(input logic [13:0] base, input logic [7:0] vpn,
                       input logic [31:0] pde, input logic [31:0] pte);
    logic [13:0] a0;
    dir_base = base;
    a0 = base + {8'd0, vpn[7:4], 2'b00};
    mem[a0] = pde;
    if (pde[31]) mem[{pde[7:0], 6'b0} | {8'd0, vpn[3:0], 2'b00}] = pte;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(walk_ready && !mem_req && !ins_valid && !flt_valid, "R1", "reset outputs",
        {walk_ready, mem_req, ins_valid, flt_valid}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(walk_ready && !mem_req, "R1", "idle after reset", {walk_ready, mem_req}, 2'b10);

    // R10 success, all permissions
    setup(14'h0100, 8'h37, ent(1, 1, 3'b000, 8'h20, 0), ent(1, 1, 3'b111, 8'h9a, 32'h5a5a5a5a));
    walk(8'h37, 3'b110, 0, 0, 0);
    // R5 invalid directory entry, table word not read
    setup(14'h0200, 8'h5c, ent(0, 1, 3'b111, 8'h21, 0), 0);
    walk(8'h5c, 3'b100, 1, 2, 1);
    // R7 invalid table entry wins over bad permissions and absence
    setup(14'h0300, 8'h81, ent(1, 0, 3'b000, 8'h22, 0), ent(0, 0, 3'b000, 8'h44, 0));
    walk(8'h81, 3'b111, 0, 1, 0);
    // R8 protection wins over absence
    setup(14'h0400, 8'h92, ent(1, 0, 3'b000, 8'h23, 0), ent(1, 0, 3'b101, 8'h45, 0));
    walk(8'h92, 3'b010, 2, 0, 1);
    // R9 valid, permitted, absent
    setup(14'h0500, 8'ha3, ent(1, 0, 3'b000, 8'h24, 0), ent(1, 0, 3'b100, 8'h46, 0));
    walk(8'ha3, 3'b100, 0, 0, 0);
    // R8 no access requested is always permitted
    setup(14'h0600, 8'hb4, ent(1, 0, 3'b000, 8'h25, 0), ent(1, 1, 3'b000, 8'h47, 0));
    walk(8'hb4, 3'b000, 0, 0, 0);
    // R3 directory address wraps at 14 bits
    setup(14'h3ff0, 8'hf9, ent(1, 0, 3'b000, 8'h26, 0), ent(1, 1, 3'b011, 8'h48, 0));
    walk(8'hf9, 3'b001, 0, 0, 1);
    // R4 long grant and response latency
    setup(14'h0700, 8'h0e, ent(1, 0, 3'b000, 8'h27, 0), ent(1, 1, 3'b010, 8'h49, 0));
    walk(8'h0e, 3'b010, 9, 25, 1);

    for (int t = 0; t < 300; t++) begin
      logic [7:0] v;
      logic [31:0] pde, pte;
      v = 8'($urandom);
      pde = ent(($urandom % 8) != 0, $urandom, 3'($urandom), 8'($urandom), $urandom);
      pte = ent(($urandom % 8) != 0, ($urandom % 5) != 0, 3'($urandom), 8'($urandom), $urandom);
      setup(14'($urandom), v, pde, pte);
      walk(v, 3'($urandom), $urandom % 4, $urandom % 6, 1'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule